// File: doc/BRIEF.md
# Byte Shift and Rotate Unit with Condition Flags

This block is the shift and rotate datapath of an accumulator-based processor. In one combinational step it returns a result byte and a fully updated flag byte for one of five operations. One operation rotates the accumulator right. Three shift a general operand byte. The last rotates nibbles between the accumulator and a byte from memory.

The surrounding core fetches the operands, decodes opcodes and sequences write-back. It presents a 3-bit operation code, the operand byte, the accumulator, the memory byte and the current flags, and it captures `result_out`, `mem_out` and `flags_out` in the same cycle. The flag byte places sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 are not owned by this unit.

Top module: `shrot_unit`

## Requirements
- R1: With op_sel = 0 (accumulator rotate right), result_out = {acc_in[0], acc_in[7:1]} and flags_out bit 0 (carry) = acc_in[0]; operand_in has no effect.
- R2: With op_sel = 0, flags_out bits 4 (half-carry) and 1 (subtract) are 0, and bits 7 (sign), 6 (zero) and 2 (parity/overflow) equal the same bits of flags_in.
- R3: With op_sel = 1 (arithmetic left shift), result_out = {operand_in[6:0], 0} and the carry flag = operand_in[7].
- R4: With op_sel = 2 (arithmetic right shift), result_out = {operand_in[7], operand_in[7:1]} and the carry flag = operand_in[0].
- R5: With op_sel = 3 (logical right shift), result_out = {0, operand_in[7:1]} and the carry flag = operand_in[0].
- R6: For op_sel 1, 2 and 3, sign = result_out[7], zero = 1 exactly when result_out is 0, parity/overflow = 1 exactly when result_out has an even number of ones (including none), and half-carry and subtract are 0.
- R7: With op_sel = 4 (nibble rotate), result_out = {acc_in[7:4], mem_in[3:0]} and mem_out = {acc_in[3:0], mem_in[7:4]}.
- R8: With op_sel = 4, sign, zero and parity/overflow are derived from result_out as in R6, half-carry and subtract are 0, and carry equals flags_in bit 0.
- R9: For every op_sel, flags_out bits 5 and 3 equal flags_in bits 5 and 3, and for op_sel other than 4, mem_out = mem_in.
- R10: op_sel values 5, 6 and 7 are no-operations: result_out = operand_in, flags_out = flags_in and mem_out = mem_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (0 rotate accumulator, 1 shift left arithmetic, 2 shift right arithmetic, 3 shift right logical, 4 nibble rotate) |
| operand_in | input | 8 | Operand byte for the three shifts |
| acc_in | input | 8 | Current accumulator value |
| mem_in | input | 8 | Memory byte used by the nibble rotate |
| flags_in | input | 8 | Current flag byte |
| result_out | output | 8 | Result byte (new accumulator for op codes 0 and 4) |
| mem_out | output | 8 | New memory byte |
| flags_out | output | 8 | Updated flag byte |

## Verification
The unit holds no state, so a wrong internal value shows at the ports in the same evaluation as the input that causes it, with no delay in cycles. A wrong bit routing in the shifter or the nibble path shows up as a result or memory byte that is off by one position or one nibble. A wrong flag policy shows up as a flag that is cleared, kept or computed when it should not be. The zero and parity flags need all-zero and single-bit results to expose them. The carry-preserve rule of the nibble rotate needs both carry values on the input.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int FLAG_W = 8;

    typedef enum logic [2:0] {
        OP_ROT_ACC = 3'd0,
        OP_SHL_AR  = 3'd1,
        OP_SHR_AR  = 3'd2,
        OP_SHR_LG  = 3'd3,
        OP_NIB_ROT = 3'd4,
        OP_NOP5    = 3'd5,
        OP_NOP6    = 3'd6,
        OP_NOP7    = 3'd7
    } op_e;

    // Flag byte layout, MSB first
    typedef struct packed {
        logic s;
        logic z;
        logic b5;
        logic h;
        logic b3;
        logic pv;
        logic n;
        logic c;
    } flag_t;

    function automatic logic is_shift(input op_e op);
        return (op == OP_SHL_AR) || (op == OP_SHR_AR) || (op == OP_SHR_LG);
    endfunction

    // Apply sign/zero/parity and clear half-carry and subtract
    function automatic flag_t szp_update(input flag_t f, input logic sign,
                                         input logic zero, input logic even);
        flag_t r;
        r    = f;
        r.s  = sign;
        r.z  = zero;
        r.pv = even;
        r.h  = 1'b0;
        r.n  = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/shrot_shifter.sv
module shrot_shifter
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] res,
    output logic              carry
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        res   = operand;
        carry = 1'b0;
        case (op)
            OP_ROT_ACC: begin
                res   = {acc[0], acc[MSB:1]};
                carry = acc[0];
            end
            OP_SHL_AR: begin
                res   = {operand[MSB-1:0], 1'b0};
                carry = operand[MSB];
            end
            OP_SHR_AR: begin
                res   = {operand[MSB], operand[MSB:1]};
                carry = operand[0];
            end
            OP_SHR_LG: begin
                res   = {1'b0, operand[MSB:1]};
                carry = operand[0];
            end
            default: begin
                res   = operand;
                carry = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/shrot_nibble.sv
module shrot_nibble #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mem,
    output logic [DATA_W-1:0] new_acc,
    output logic [DATA_W-1:0] new_mem
);
    localparam int HALF = DATA_W / 2;

    // Accumulator keeps its upper half, takes the memory lower half
    assign new_acc = {acc[DATA_W-1:HALF], mem[HALF-1:0]};
    // Memory: upper half from old accumulator lower half, lower half from old memory upper half
    assign new_mem = {acc[HALF-1:0], mem[DATA_W-1:HALF]};
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] res,
    input  logic              carry,
    input  flag_t             fin,
    output flag_t             fout
);
    logic sign_b, zero_b, even_b;

    assign sign_b = res[DATA_W-1];
    assign zero_b = ~|res;
    assign even_b = ~^res;

    always_comb begin
        fout = fin;
        if (op == OP_ROT_ACC) begin
            fout.h = 1'b0;
            fout.n = 1'b0;
            fout.c = carry;
        end else if (is_shift(op)) begin
            fout   = szp_update(fin, sign_b, zero_b, even_b);
            fout.c = carry;
        end else if (op == OP_NIB_ROT) begin
            fout = szp_update(fin, sign_b, zero_b, even_b);
        end
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] operand_in,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] mem_in,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] result_out,
    output logic [DATA_W-1:0] mem_out,
    output logic [7:0]        flags_out
);
    op_e               op;
    logic [DATA_W-1:0] sh_res;
    logic              sh_carry;
    logic [DATA_W-1:0] nb_acc;
    logic [DATA_W-1:0] nb_mem;
    flag_t             f_in;
    flag_t             f_out;

    assign op   = op_e'(op_sel);
    assign f_in = flag_t'(flags_in);

    shrot_shifter #(.DATA_W(DATA_W)) u_shift (
        .op      (op),
        .operand (operand_in),
        .acc     (acc_in),
        .res     (sh_res),
        .carry   (sh_carry)
    );

    shrot_nibble #(.DATA_W(DATA_W)) u_nib (
        .acc     (acc_in),
        .mem     (mem_in),
        .new_acc (nb_acc),
        .new_mem (nb_mem)
    );

    assign result_out = (op == OP_NIB_ROT) ? nb_acc : sh_res;
    assign mem_out    = (op == OP_NIB_ROT) ? nb_mem : mem_in;

    shrot_flags #(.DATA_W(DATA_W)) u_flags (
        .op    (op),
        .res   (result_out),
        .carry (sh_carry),
        .fin   (f_in),
        .fout  (f_out)
    );

    assign flags_out = f_out;
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk #(
    parameter int DATA_W = 8
) (
    input logic [2:0]        op_sel,
    input logic [DATA_W-1:0] operand_in,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] mem_in,
    input logic [7:0]        flags_in,
    input logic [DATA_W-1:0] result_out,
    input logic [DATA_W-1:0] mem_out,
    input logic [7:0]        flags_out
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        // R1
        rot_carry_chk: assert (op_sel != 3'd0 ||
            (flags_out[0] == acc_in[0] && result_out[MSB] == acc_in[0]))
            else $error("rotate carry mismatch");
        // R2
        rot_keep_chk: assert (op_sel != 3'd0 ||
            (flags_out[7] == flags_in[7] && flags_out[6] == flags_in[6] &&
             flags_out[2] == flags_in[2] && !flags_out[4] && !flags_out[1]))
            else $error("rotate flag policy broken");
        // R6
        shift_zp_chk: assert (!(op_sel inside {3'd1, 3'd2, 3'd3}) ||
            (flags_out[6] == (result_out == '0) &&
             flags_out[2] == ($countones(result_out) % 2 == 0) &&
             flags_out[7] == result_out[MSB]))
            else $error("shift flags wrong");
        // R8
        nib_carry_chk: assert (op_sel != 3'd4 ||
            (flags_out[0] == flags_in[0] &&
             result_out[MSB:DATA_W/2] == acc_in[MSB:DATA_W/2]))
            else $error("nibble rotate carry or upper half changed");
        // R9
        spare_bits_chk: assert (flags_out[5] == flags_in[5] &&
            flags_out[3] == flags_in[3])
            else $error("spare flag bits altered");
        // R10
        nop_chk: assert (op_sel < 3'd5 ||
            (result_out == operand_in && flags_out == flags_in && mem_out == mem_in))
            else $error("reserved code not a no-op");
    end
endmodule

bind shrot_unit shrot_chk #(.DATA_W(DATA_W)) u_chk (
    .op_sel     (op_sel),
    .operand_in (operand_in),
    .acc_in     (acc_in),
    .mem_in     (mem_in),
    .flags_in   (flags_in),
    .result_out (result_out),
    .mem_out    (mem_out),
    .flags_out  (flags_out)
);

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [2:0] op_sel;
    logic [7:0] operand_in, acc_in, mem_in, flags_in;
    logic [7:0] result_out, mem_out, flags_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    shrot_unit dut (
        .op_sel     (op_sel),
        .operand_in (operand_in),
        .acc_in     (acc_in),
        .mem_in     (mem_in),
        .flags_in   (flags_in),
        .result_out (result_out),
        .mem_out    (mem_out),
        .flags_out  (flags_out)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] opd;
        logic [7:0] acc;
        logic [7:0] mem;
        logic [7:0] fl;
        logic [7:0] e_res;
        logic [7:0] e_mem;
        logic [7:0] e_fl;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'h33, 8'h01, 8'h5A, 8'hFF, 8'h80, 8'h5A, 8'hED},
        '{3'd0, 8'hFF, 8'h02, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00},
        '{3'd1, 8'h81, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00, 8'h01},
        '{3'd1, 8'h80, 8'h00, 8'h00, 8'h28, 8'h00, 8'h00, 8'h6D},
        '{3'd2, 8'h85, 8'h00, 8'h00, 8'hFF, 8'hC2, 8'h00, 8'hA9},
        '{3'd3, 8'h85, 8'h00, 8'h00, 8'h00, 8'h42, 8'h00, 8'h05},
        '{3'd3, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h45},
        '{3'd4, 8'h00, 8'h12, 8'h34, 8'h01, 8'h14, 8'h23, 8'h05},
        '{3'd4, 8'h00, 8'h80, 8'h00, 8'hFE, 8'h80, 8'h00, 8'hA8},
        '{3'd4, 8'h00, 8'h05, 8'h50, 8'h00, 8'h00, 8'h55, 8'h44},
        '{3'd5, 8'h3C, 8'h00, 8'h77, 8'h93, 8'h3C, 8'h77, 8'h93},
        '{3'd7, 8'hA5, 8'h00, 8'h11, 8'h00, 8'hA5, 8'h11, 8'h00},
        '{3'd2, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h45}
    };

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1/R2";
            3'd1: return "R3/R6";
            3'd2: return "R4/R6";
            3'd3: return "R5/R6";
            3'd4: return "R7/R8";
            default: return "R10";
        endcase
    endfunction

    // Reference model written from the requirements
    function automatic logic [23:0] model(input logic [2:0] op, input logic [7:0] opd,
                                          input logic [7:0] acc, input logic [7:0] mem,
                                          input logic [7:0] fl);
        logic [7:0] r, m, f;
        r = opd; m = mem; f = fl;
        case (op)
            3'd0: begin r = {acc[0], acc[7:1]}; f[4] = 0; f[1] = 0; f[0] = acc[0]; end
            3'd1: begin r = {opd[6:0], 1'b0}; f[0] = opd[7]; end
            3'd2: begin r = {opd[7], opd[7:1]}; f[0] = opd[0]; end
            3'd3: begin r = {1'b0, opd[7:1]}; f[0] = opd[0]; end
            3'd4: begin r = {acc[7:4], mem[3:0]}; m = {acc[3:0], mem[7:4]}; end
            default: ;
        endcase
        if (op inside {3'd1, 3'd2, 3'd3, 3'd4}) begin
            f[7] = r[7];
            f[6] = (r == 8'h00);
            f[2] = ($countones(r) % 2 == 0);
            f[4] = 0;
            f[1] = 0;
        end
        return {r, m, f};
    endfunction

    task automatic check3(input string tag, input logic [7:0] er,
                          input logic [7:0] em, input logic [7:0] ef);
        checks++;
        if (result_out !== er || mem_out !== em || flags_out !== ef) begin
            errors++;
            $display("FAIL %s op=%0d: actual res=%02h mem=%02h fl=%02h expected res=%02h mem=%02h fl=%02h",
                     tag, op_sel, result_out, mem_out, flags_out, er, em, ef);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [7:0] opd,
                         input logic [7:0] acc, input logic [7:0] mem,
                         input logic [7:0] fl);
        @(negedge clk);
        op_sel = op; operand_in = opd; acc_in = acc; mem_in = mem; flags_in = fl;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [23:0] e;
        op_sel = 3'd0; operand_in = 8'h00; acc_in = 8'h00; mem_in = 8'h00; flags_in = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        // Reset state with quiet inputs: rotate of zero gives zero (R1)
        check3("R1 reset", 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // Table of hand-computed vectors
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].opd, VECS[i].acc, VECS[i].mem, VECS[i].fl);
            check3(tag_of(VECS[i].op), VECS[i].e_res, VECS[i].e_mem, VECS[i].e_fl);
        end

        // R1: operand has no effect on the accumulator rotate
        apply(3'd0, 8'hFF, 8'hAA, 8'h00, 8'h00);
        check3("R1 operand ignored", 8'h55, 8'h00, 8'h00);
        // R9: spare flag bits pass through on nibble rotate with carry clear
        apply(3'd4, 8'h00, 8'hF0, 8'h0F, 8'h28);
        check3("R9 spare bits", 8'hFF, 8'h00, 8'hAC);
        // R8: carry set preserved when the new accumulator is zero
        apply(3'd4, 8'h00, 8'h0C, 8'hA0, 8'h01);
        check3("R8 carry kept", 8'h00, 8'hCA, 8'h45);
        // R6: shift left of 0xFF, seven ones => parity odd
        apply(3'd1, 8'hFF, 8'h00, 8'h00, 8'h00);
        check3("R6 odd parity", 8'hFE, 8'h00, 8'h81);

        // Sweep of every op code against the model
        for (int op = 0; op < 8; op++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] a, m, f;
                a = 8'(v) ^ 8'h5A;
                m = 8'(v * 3);
                f = 8'(v * 7 + op);
                apply(3'(op), 8'(v), a, m, f);
                e = model(3'(op), 8'(v), a, m, f);
                check3({tag_of(3'(op)), " R9 sweep"}, e[23:16], e[15:8], e[7:0]);
            end
        end
        finish_run();
    end
endmodule